// File: doc/BRIEF.md
# Multi-channel DMA channel controller

This block keeps the per-channel control state for a small group of DMA channels and decides, one request at a time, whether a peripheral's transfer may go ahead. Software programs each channel through a 32-bit register port. Each channel has a mode word, a remaining byte count and a start address. The mode word holds an enable bit, a direction bit and three interrupt flags.

A peripheral presents a request with a channel index, a length and a direction. The controller first clears the three interrupt flags of that channel. It then checks the request against the channel's mode word. A rejected request sets the memory-error flag and a sticky bit in a shared error-source word. An accepted request produces a burst descriptor for a downstream data mover. The descriptor carries the channel's address, the requested length clamped to the remaining count, and the direction. The accepted request also sets the terminal-count flag and reduces the count. Each channel drives an interrupt line that is high while any of its three flags is set. Data movement and address translation belong to other blocks.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every channel register and the error-source word read as zero, `desc_valid` is low and every `irq` bit is low.
- R2: Register byte offsets are as follows. For channel n, the mode word is at n*32+8, the count at n*32+16 and the address at n*32+24; all three store all 32 bits written. The error-source word is at NUM_CH*32. Bits [2:0] of the offset are ignored. Offset n*32+0 and every offset outside the map read as zero, and writes to them change nothing.
- R3: A request to an existing channel first clears mode bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel, whatever the outcome of the request.
- R4: A request is rejected when mode bit 0 (enable) is 0, or when `req_to_dev` differs from mode bit 1 (1 = memory to device, 0 = device to memory). A rejected request sets mode bit 9 and error-source bit n, issues no descriptor and leaves the count unchanged.
- R5: An accepted request raises `desc_valid` for exactly the clock cycle after the request. The descriptor carries the channel index, the channel's address word, the direction of the request and the clamped length. The request also sets mode bit 8.
- R6: The clamped length is the smaller of `req_len` and the count word. The count word is reduced by that length. A request on a zero count is accepted with a zero-length descriptor.
- R7: The error-source word cannot be written by software. Its bits stay set until reset.
- R8: `irq[n]` is the OR of mode bits 8, 9 and 10 of channel n. This includes flags set by software writes.
- R9: A request whose channel index is NUM_CH or above issues no descriptor and changes no register.
- R10: When a software write and a request update the same register in the same cycle, the written value is stored. The request is still judged and clamped on the values held before that cycle.
- R11: Transfers never change a channel's address word. Every `desc_valid` pulse lasts one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | REG_AW | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| req_valid | input | 1 | Transfer request strobe |
| req_chan | input | CH_W | Requested channel index |
| req_len | input | LEN_W | Requested length in bytes |
| req_to_dev | input | 1 | Requested direction: 1 memory to device, 0 device to memory |
| desc_valid | output | 1 | Burst descriptor valid, one cycle per accepted request |
| desc_chan | output | CH_W | Descriptor channel index |
| desc_addr | output | 32 | Descriptor start address |
| desc_len | output | LEN_W | Descriptor length after clamping |
| desc_to_dev | output | 1 | Descriptor direction |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench builds the block with three channels, a 16-bit length and a 9-bit register offset. With three channels the 2-bit channel index can name a channel that does not exist, so the out-of-range request case becomes reachable. The error-source word also moves to offset 0x60, away from any power-of-two boundary, which tests the derived decode. Clamping to a count smaller than the request, zero-count transfers, and a write that collides with a request on the same register are all driven directly.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int DW = 32;

  // mode word bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_TODEV = 1;
  localparam int BIT_TC    = 8;
  localparam int BIT_MERR  = 9;
  localparam int BIT_AERR  = 10;

  // register layout: channel span 32 bytes, slot span 8 bytes
  localparam int CH_SPAN_LOG = 5;
  localparam int SLOT_LOG    = 3;

  typedef enum logic [1:0] {
    SLOT_RSVD  = 2'd0,
    SLOT_MODE  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_ADDR  = 2'd3
  } slot_e;

  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/dma_cc_rstsync.sv
module dma_cc_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dma_cc_regdec.sv
module dma_cc_regdec
  import dma_cc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_AW = 9
) (
  input  logic [REG_AW-1:SLOT_LOG] word_addr,
  output logic [NUM_CH-1:0]        ch_hit,
  output slot_e                    slot,
  output logic                     err_hit
);
  localparam int CHF_W    = REG_AW - CH_SPAN_LOG;
  localparam int WRD_W    = REG_AW - SLOT_LOG;
  localparam int ERR_WORD = (NUM_CH << CH_SPAN_LOG) >> SLOT_LOG;

  logic [CHF_W-1:0] ch_field;

  assign ch_field = word_addr[REG_AW-1:CH_SPAN_LOG];
  assign slot     = slot_e'(word_addr[CH_SPAN_LOG-1:SLOT_LOG]);
  assign err_hit  = (word_addr == WRD_W'(ERR_WORD));        // R2

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign ch_hit[i] = (ch_field == CHF_W'(i));
    end
  endgenerate
endmodule

// File: rtl/dma_cc_chan.sv
module dma_cc_chan
  import dma_cc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_count,
  input  logic             wr_addr,
  input  word_t            wdata,
  input  logic             upd,
  input  logic             upd_ok,
  input  logic [LEN_W-1:0] upd_len,
  output word_t            mode_q,
  output word_t            count_q,
  output word_t            addr_q,
  output logic             irq
);
  word_t mode_d;
  word_t count_d;
  logic  mode_en;
  logic  count_en;

  always_comb begin
    mode_d = mode_q;
    if (upd) begin
      mode_d[BIT_AERR:BIT_TC] = '0;                         // R3
      if (upd_ok) mode_d[BIT_TC]   = 1'b1;                  // R5
      else        mode_d[BIT_MERR] = 1'b1;                  // R4
    end
    if (wr_mode) mode_d = wdata;                            // R10 write wins

    count_d = count_q;
    if (upd && upd_ok) count_d = count_q - word_t'(upd_len); // R6
    if (wr_count) count_d = wdata;                          // R10
  end

  assign mode_en  = wr_mode | upd;
  assign count_en = wr_count | (upd & upd_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  // R11: only software loads the address word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_addr) begin
      addr_q <= wdata;
    end
  end

  assign irq = |mode_q[BIT_AERR:BIT_TC];                    // R8
endmodule

// File: rtl/dma_cc_req.sv
module dma_cc_req
  import dma_cc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 16,
  parameter int CH_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [CH_W-1:0]           req_chan,
  input  logic [LEN_W-1:0]          req_len,
  input  logic                      req_to_dev,
  input  logic [NUM_CH-1:0]         ch_en,
  input  logic [NUM_CH-1:0]         ch_todev,
  input  logic [NUM_CH-1:0][DW-1:0] ch_count,
  input  logic [NUM_CH-1:0][DW-1:0] ch_addr,
  output logic [NUM_CH-1:0]         upd,
  output logic                      upd_ok,
  output logic [LEN_W-1:0]          upd_len,
  output logic [NUM_CH-1:0]         err_q,
  output logic                      desc_valid,
  output logic [CH_W-1:0]           desc_chan,
  output word_t                     desc_addr,
  output logic [LEN_W-1:0]          desc_len,
  output logic                      desc_to_dev
);
  logic              in_range;
  logic              sel_en;
  logic              sel_todev;
  word_t             sel_count;
  word_t             sel_addr;
  logic              accept;
  logic              reject;
  logic [NUM_CH-1:0] err_d;

  always_comb begin
    in_range  = 1'b0;
    sel_en    = 1'b0;
    sel_todev = 1'b0;
    sel_count = '0;
    sel_addr  = '0;
    upd       = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_chan == CH_W'(i)) begin
        in_range  = 1'b1;
        sel_en    = ch_en[i];
        sel_todev = ch_todev[i];
        sel_count = ch_count[i];
        sel_addr  = ch_addr[i];
        upd[i]    = req_valid;
      end
    end
  end

  // R4: enable and direction agreement
  assign upd_ok  = sel_en & (sel_todev == req_to_dev);
  // R6: clamp to remaining count
  assign upd_len = (sel_count < word_t'(req_len)) ? sel_count[LEN_W-1:0] : req_len;

  assign accept = req_valid & in_range & upd_ok;            // R9 range gate
  assign reject = req_valid & in_range & ~upd_ok;
  assign err_d  = err_q | upd;

  // R7: sticky, set only by rejected requests, cleared only by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (reject) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_valid <= 1'b0;
    end else begin
      desc_valid <= accept;                                 // R5 R11
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_chan   <= '0;
      desc_addr   <= '0;
      desc_len    <= '0;
      desc_to_dev <= 1'b0;
    end else if (accept) begin
      desc_chan   <= req_chan;
      desc_addr   <= sel_addr;
      desc_len    <= upd_len;
      desc_to_dev <= req_to_dev;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 16,
  parameter int REG_AW = 9,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_to_dev,
  output logic              desc_valid,
  output logic [CH_W-1:0]   desc_chan,
  output logic [DW-1:0]     desc_addr,
  output logic [LEN_W-1:0]  desc_len,
  output logic              desc_to_dev,
  output logic [NUM_CH-1:0] irq
);
  // REG_AW must hold NUM_CH*32 + 8 byte offsets
  logic                      srst_n;
  logic                      unused_low;
  logic [NUM_CH-1:0]         ch_hit;
  slot_e                     slot;
  logic                      err_hit;
  logic [NUM_CH-1:0]         upd;
  logic                      upd_ok;
  logic [LEN_W-1:0]          upd_len;
  logic [NUM_CH-1:0]         err_q;
  logic [NUM_CH-1:0][DW-1:0] mode_w;
  logic [NUM_CH-1:0][DW-1:0] count_w;
  logic [NUM_CH-1:0][DW-1:0] addr_w;
  logic [NUM_CH-1:0]         ch_en;
  logic [NUM_CH-1:0]         ch_todev;

  assign unused_low = ^reg_addr[SLOT_LOG-1:0];

  dma_cc_rstsync u_rstsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dma_cc_regdec #(
    .NUM_CH (NUM_CH),
    .REG_AW (REG_AW)
  ) u_regdec (
    .word_addr (reg_addr[REG_AW-1:SLOT_LOG]),
    .ch_hit    (ch_hit),
    .slot      (slot),
    .err_hit   (err_hit)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic wr_mode;
      logic wr_count;
      logic wr_addr;
      word_t mode_q;
      word_t count_q;
      word_t addr_q;

      assign wr_mode  = reg_we & ch_hit[i] & (slot == SLOT_MODE);
      assign wr_count = reg_we & ch_hit[i] & (slot == SLOT_COUNT);
      assign wr_addr  = reg_we & ch_hit[i] & (slot == SLOT_ADDR);

      dma_cc_chan #(
        .LEN_W (LEN_W)
      ) u_chan (
        .clk      (clk),
        .rst_n    (srst_n),
        .wr_mode  (wr_mode),
        .wr_count (wr_count),
        .wr_addr  (wr_addr),
        .wdata    (reg_wdata),
        .upd      (upd[i]),
        .upd_ok   (upd_ok),
        .upd_len  (upd_len),
        .mode_q   (mode_q),
        .count_q  (count_q),
        .addr_q   (addr_q),
        .irq      (irq[i])
      );

      assign mode_w[i]   = mode_q;
      assign count_w[i]  = count_q;
      assign addr_w[i]   = addr_q;
      assign ch_en[i]    = mode_q[BIT_EN];
      assign ch_todev[i] = mode_q[BIT_TODEV];
    end
  endgenerate

  dma_cc_req #(
    .NUM_CH (NUM_CH),
    .LEN_W  (LEN_W),
    .CH_W   (CH_W)
  ) u_req (
    .clk         (clk),
    .rst_n       (srst_n),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .req_len     (req_len),
    .req_to_dev  (req_to_dev),
    .ch_en       (ch_en),
    .ch_todev    (ch_todev),
    .ch_count    (count_w),
    .ch_addr     (addr_w),
    .upd         (upd),
    .upd_ok      (upd_ok),
    .upd_len     (upd_len),
    .err_q       (err_q),
    .desc_valid  (desc_valid),
    .desc_chan   (desc_chan),
    .desc_addr   (desc_addr),
    .desc_len    (desc_len),
    .desc_to_dev (desc_to_dev)
  );

  // R2: AND-OR read mux, reserved and unmapped offsets give zero
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (slot)
          SLOT_MODE:  reg_rdata = mode_w[i];
          SLOT_COUNT: reg_rdata = count_w[i];
          SLOT_ADDR:  reg_rdata = addr_w[i];
          default:    reg_rdata = '0;
        endcase
      end
    end
    if (err_hit) reg_rdata = DW'(err_q);                    // R7
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 16,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CH_W-1:0]   req_chan,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_to_dev,
  input logic              reg_we,
  input logic              desc_valid,
  input logic [CH_W-1:0]   desc_chan,
  input logic [LEN_W-1:0]  desc_len,
  input logic              desc_to_dev,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] err_q
);
  AST_DESC_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $past(req_valid)); // R11

  AST_DESC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_chan == $past(req_chan)) && (desc_to_dev == $past(req_to_dev))); // R5

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_len <= $past(req_len)); // R6

  AST_BADCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && (int'($past(req_chan)) >= NUM_CH)) |-> !desc_valid); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_q) & ~err_q) == '0)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_valid) && !$past(reg_we)) |-> $stable(irq)); // R8
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(
  .NUM_CH (NUM_CH),
  .LEN_W  (LEN_W),
  .CH_W   (CH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_chan    (req_chan),
  .req_len     (req_len),
  .req_to_dev  (req_to_dev),
  .reg_we      (reg_we),
  .desc_valid  (desc_valid),
  .desc_chan   (desc_chan),
  .desc_len    (desc_len),
  .desc_to_dev (desc_to_dev),
  .irq         (irq),
  .err_q       (err_q)
);

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
  localparam int NCH = 3;
  localparam int LW  = 16;
  localparam int AW  = 9;
  localparam int CW  = 2;
  localparam int ERR_OFS = NCH * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] reg_addr;
  logic          reg_we;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          req_valid;
  logic [CW-1:0] req_chan;
  logic [LW-1:0] req_len;
  logic          req_to_dev;
  logic          desc_valid;
  logic [CW-1:0] desc_chan;
  logic [31:0]   desc_addr;
  logic [LW-1:0] desc_len;
  logic          desc_to_dev;
  logic [NCH-1:0] irq;

  always #10 clk = ~clk;

  dma_chan_ctrl #(.NUM_CH(NCH), .LEN_W(LW), .REG_AW(AW)) u_dma_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_chan(req_chan), .req_len(req_len), .req_to_dev(req_to_dev),
    .desc_valid(desc_valid), .desc_chan(desc_chan), .desc_addr(desc_addr),
    .desc_len(desc_len), .desc_to_dev(desc_to_dev), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 0;

  // behavioural reference state
  logic [31:0] m_mode [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [31:0] m_adr  [NCH];
  logic [31:0] m_err;
  logic        e_valid;
  logic [CW-1:0] e_chan;
  logic [31:0] e_addr;
  logic [LW-1:0] e_len;
  logic        e_dir;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int a);
    if (a < NCH * 32) begin
      case ((a >> 3) & 3)
        1:       return m_mode[a >> 5];
        2:       return m_cnt[a >> 5];
        3:       return m_adr[a >> 5];
        default: return 32'h0;
      endcase
    end else if ((a >> 3) == (ERR_OFS >> 3)) begin
      return m_err;
    end
    return 32'h0;
  endfunction

  task automatic model_tick();
    int c;
    int a;
    logic ok;
    logic [31:0] l;
    e_valid = 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_mode[i] = 0; m_cnt[i] = 0; m_adr[i] = 0;
      end
      m_err = 0;
      return;
    end
    if (req_valid && int'(req_chan) < NCH) begin
      c  = int'(req_chan);
      ok = m_mode[c][0] && (m_mode[c][1] == req_to_dev);
      m_mode[c][10:8] = 3'b000;
      if (ok) begin
        l = (m_cnt[c] < 32'(req_len)) ? m_cnt[c] : 32'(req_len);
        e_valid = 1'b1; e_chan = req_chan; e_addr = m_adr[c];
        e_len = l[LW-1:0]; e_dir = req_to_dev;
        m_cnt[c] = m_cnt[c] - l;
        m_mode[c][8] = 1'b1;
      end else begin
        m_mode[c][9] = 1'b1;
        m_err[c] = 1'b1;
      end
    end
    if (reg_we) begin
      a = int'(reg_addr);
      if (a < NCH * 32) begin
        case ((a >> 3) & 3)
          1: m_mode[a >> 5] = reg_wdata;
          2: m_cnt[a >> 5]  = reg_wdata;
          3: m_adr[a >> 5]  = reg_wdata;
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare_all();
    logic [NCH-1:0] e_irq;
    for (int i = 0; i < NCH; i++) e_irq[i] = |m_mode[i][10:8];
    chk("R5 desc_valid", 32'(desc_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R5 desc_chan", 32'(desc_chan), 32'(e_chan));
      chk("R5 desc_addr", desc_addr, e_addr);
      chk("R6 desc_len", 32'(desc_len), 32'(e_len));
      chk("R5 desc_to_dev", 32'(desc_to_dev), 32'(e_dir));
    end
    chk("R8 irq", 32'(irq), 32'(e_irq));
    chk("R2 reg_rdata", reg_rdata, m_read(int'(reg_addr)));
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_wr(int a, logic [31:0] d);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic do_req(int c, int len, bit dir);
    req_valid = 1'b1; req_chan = CW'(c); req_len = LW'(len); req_to_dev = dir;
    step();
    req_valid = 1'b0;
  endtask

  task automatic expect_rd(int a, logic [31:0] exp, string tag);
    reg_addr = AW'(a);
    step();
    chk(tag, reg_rdata, exp);
  endtask

  function automatic int om(int c); return c * 32 + 8;  endfunction
  function automatic int oc(int c); return c * 32 + 16; endfunction
  function automatic int oa(int c); return c * 32 + 24; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    req_valid = 1'b0; req_chan = '0; req_len = '0; req_to_dev = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      m_mode[i] = 0; m_cnt[i] = 0; m_adr[i] = 0;
    end
    m_err = 0; e_valid = 0; e_chan = 0; e_addr = 0; e_len = 0; e_dir = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 desc_valid", 32'(desc_valid), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (3) step();

    for (int c = 0; c < NCH; c++) begin
      expect_rd(om(c), 32'h0, "R1 mode");
      expect_rd(oc(c), 32'h0, "R1 count");
      expect_rd(oa(c), 32'h0, "R1 addr");
    end
    expect_rd(ERR_OFS, 32'h0, "R1 err");

    // R2 programming
    do_wr(om(0), 32'h1);
    do_wr(oc(0), 32'd100);
    do_wr(oa(0), 32'h1000_0000);
    do_wr(om(1), 32'h3);
    do_wr(oc(1), 32'd10);
    do_wr(oa(1), 32'h0000_2000);
    expect_rd(om(0), 32'h1, "R2 mode rb");
    expect_rd(oc(0) + 4, 32'd100, "R2 count rb low bits ignored");
    expect_rd(oa(0), 32'h1000_0000, "R2 addr rb");
    do_wr(32, 32'hFFFF_FFFF);
    expect_rd(32, 32'h0, "R2 reserved slot");
    expect_rd(om(1), 32'h3, "R2 reserved write no effect");
    do_wr(ERR_OFS + 8, 32'hFFFF_FFFF);
    expect_rd(ERR_OFS + 8, 32'h0, "R2 unmapped");

    // R5 accepted transfer
    do_req(0, 40, 1'b0);
    chk("R5 desc_valid", 32'(desc_valid), 32'h1);
    chk("R5 desc_addr", desc_addr, 32'h1000_0000);
    chk("R5 desc_len", 32'(desc_len), 32'd40);
    step();
    chk("R11 single pulse", 32'(desc_valid), 32'h0);
    expect_rd(om(0), 32'h101, "R5 tc flag");
    chk("R8 irq0", 32'(irq[0]), 32'h1);
    expect_rd(oc(0), 32'd60, "R6 count reduced");

    // R6 clamping and zero count
    do_req(0, 100, 1'b0);
    chk("R6 clamp len", 32'(desc_len), 32'd60);
    expect_rd(oc(0), 32'd0, "R6 count zero");
    do_req(0, 5, 1'b0);
    chk("R6 zero-count valid", 32'(desc_valid), 32'h1);
    chk("R6 zero-count len", 32'(desc_len), 32'd0);

    // R4 direction mismatch
    do_req(1, 4, 1'b0);
    chk("R4 no desc", 32'(desc_valid), 32'h0);
    expect_rd(om(1), 32'h203, "R4 merr flag");
    expect_rd(oc(1), 32'd10, "R4 count kept");
    expect_rd(ERR_OFS, 32'h2, "R4 err bit");

    // R3 flags cleared at request start
    do_wr(om(1), 32'h703);
    do_req(1, 4, 1'b1);
    chk("R3 desc_to_dev", 32'(desc_to_dev), 32'h1);
    expect_rd(om(1), 32'h103, "R3 flags cleared");
    expect_rd(oc(1), 32'd6, "R6 count ch1");

    // R4 disabled channel
    do_req(2, 4, 1'b1);
    chk("R4 disabled no desc", 32'(desc_valid), 32'h0);
    expect_rd(om(2), 32'h200, "R4 disabled merr");
    expect_rd(ERR_OFS, 32'h6, "R4 err bits");

    // R7 read-only error word
    do_wr(ERR_OFS, 32'h0);
    expect_rd(ERR_OFS, 32'h6, "R7 write ignored");

    // R9 out-of-range channel
    do_req(3, 4, 1'b0);
    chk("R9 no desc", 32'(desc_valid), 32'h0);
    expect_rd(om(0), 32'h101, "R9 ch0 kept");
    expect_rd(om(1), 32'h103, "R9 ch1 kept");
    expect_rd(ERR_OFS, 32'h6, "R9 err kept");

    // R10 collisions
    do_wr(oc(0), 32'd20);
    reg_addr = AW'(oc(0)); reg_wdata = 32'd50; reg_we = 1'b1;
    req_valid = 1'b1; req_chan = 2'd0; req_len = 16'd8; req_to_dev = 1'b0;
    step();
    reg_we = 1'b0; req_valid = 1'b0;
    chk("R10 len from old count", 32'(desc_len), 32'd8);
    expect_rd(oc(0), 32'd50, "R10 count write wins");
    reg_addr = AW'(om(0)); reg_wdata = 32'h1; reg_we = 1'b1;
    req_valid = 1'b1; req_chan = 2'd0; req_len = 16'd8; req_to_dev = 1'b0;
    step();
    reg_we = 1'b0; req_valid = 1'b0;
    expect_rd(om(0), 32'h1, "R10 mode write wins");
    expect_rd(oc(0), 32'd42, "R10 count reduced");

    // R11 address untouched
    expect_rd(oa(0), 32'h1000_0000, "R11 addr kept");

    // R8 software flags
    do_wr(om(1), 32'h3);
    chk("R8 irq1 low", 32'(irq[1]), 32'h0);
    do_wr(om(2), 32'h400);
    chk("R8 irq2 aerr", 32'(irq[2]), 32'h1);

    // R7 cleared only by reset
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    repeat (3) step();
    expect_rd(ERR_OFS, 32'h0, "R7 cleared by reset");
    expect_rd(om(0), 32'h0, "R1 mode after reset");

    report();
  end
endmodule